// File: doc/BRIEF.md
# Short-Cycling Serial Converter Reader

This block is the host side of a three-wire link to a successive-approximation converter that has a differential input and a two's-complement output. A one-cycle start request in idle pulls the active-low select line down, which begins a conversion. The block then makes a data clock from the system clock through a programmable half-period divider. The converter uses the first two data-clock periods to sample its input and then sends one zero bit. After that it shifts out its result, most significant bit first, and it changes its data line on each falling edge. The host reads the line on rising edges. It throws away the first three rising edges and keeps the next N (1 to 12), MSB first.

Once the Nth result bit has been taken, the host ends that high phase by raising select at the same moment the data clock falls. This cuts the conversion short and puts the converter into full power-down. The partial result is placed at the top of a 12-bit word with zeros below it, sign-extended to the output width and presented with a one-cycle valid strobe. In the same cycle, a range flag reports whether the aligned value lies above an upper signed threshold or below a lower one. Select stays high for one more half period before a new request is accepted.

The sequencer has five states. `ST_IDLE`: select high, clock low, waiting for a start request. `ST_LEAD`: select low, clock low, one half period to meet select-to-clock setup. `ST_SCK_HI`: clock high, entered on each rising edge, when a bit is read. `ST_SCK_LO`: clock low between high phases. `ST_RECOVER`: select high again for one half period. The transitions are: start in idle goes to lead. Lead expiry goes to high. High expiry goes to low, or to recover if the last edge has been reached. Low expiry goes to high. Recover expiry goes to idle.

Top module: `adc_shortcycle_host`

## Requirements
- R1: After reset, `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `valid_o`=0, `sample_o`=0 and `out_of_range_o`=0.
- R2: A start request sampled in idle lowers `cs_n_o` and raises `busy_o` one clock later. `sclk_o` then stays low for one half period before its first rise.
- R3: Each high phase and each low phase of `sclk_o` lasts exactly `div_half`+1 system clocks, counting the lead phase. `sclk_o` is never high while `cs_n_o` is high.
- R4: A conversion gives exactly N+3 rising edges of `sclk_o`. Result bit k (k=0 is B11) is the `sdata_i` value sampled at rising edge k+4, so the first three edges (two sampling periods and the zero bit) are discarded.
- R5: At the end of the high phase of rising edge N+3, `cs_n_o` rises and `sclk_o` falls in the same cycle, and `valid_o` pulses for one cycle in that same cycle. From the start edge to `valid_o` there are 2·(`div_half`+1)·(N+3) clocks.
- R6: `sample_o` equals the N received bits placed at bits 11 down to 12−N, with lower bits zero, read as a signed 12-bit value and sign-extended to OUT_W bits.
- R7: An `nbits` value of 0 is treated as 1 and values above 12 as 12. `nbits` and `div_half` are latched at start, and later changes do not affect that conversion.
- R8: A start request while `busy_o` is high is ignored, including during recovery. `cs_n_o` stays high for `div_half`+1 clocks after each conversion before `busy_o` falls.
- R9: `out_of_range_o` is updated with `valid_o`. It is 1 exactly when the aligned 12-bit signed value is greater than `win_hi` or less than `win_lo`.
- R10: `sample_o` and `out_of_range_o` keep their values between valid strobes.
- R11: With N=12, the converter's trailing LSB-first repeat is never clocked, so at most 15 rising edges occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, accepted only in idle |
| nbits | input | 4 | Number of result bits to keep (clamped to 1..12) |
| div_half | input | DIV_W | Data-clock half period minus one, in system clocks |
| win_hi | input | 12 | Upper signed threshold on the aligned value |
| win_lo | input | 12 | Lower signed threshold on the aligned value |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | Conversion or recovery in progress |
| valid_o | output | 1 | One-cycle result strobe |
| sample_o | output | OUT_W | Aligned, sign-extended result |
| out_of_range_o | output | 1 | Window violation flag for the current result |

## Verification
The assertions assume that `sdata_i` changes only after a falling edge of `sclk_o`, and is therefore stable at every rising edge. They also assume that `win_hi` and `win_lo` do not move while a result is being registered. The bench's converter model updates its data half a system clock after it sees the data clock fall, and the thresholds are written only before a conversion starts. Start requests and configuration changes made while a conversion is running are issued on purpose, to show that they are ignored rather than to break these assumptions.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    // Rising edges discarded before B11: two sampling periods plus the zero bit.
    localparam int SKIP_EDGES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_RECOVER
    } host_state_e;

endpackage

// File: rtl/adc_halfper_timer.sv
module adc_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] half,
    output logic             done
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= half;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
    parameter int RES   = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             strobe,
    input  logic [CNT_W-1:0] rise_idx,
    input  logic             sdata,
    output logic [RES-1:0]   acc
);
    import adc_host_pkg::*;

    localparam int IDX_W = $clog2(RES);

    logic [IDX_W-1:0] pos;
    logic             in_range;

    always_comb begin
        pos      = IDX_W'(RES + SKIP_EDGES - int'(rise_idx));
        in_range = (rise_idx > CNT_W'(SKIP_EDGES)) &&
                   (rise_idx <= CNT_W'(RES + SKIP_EDGES));
    end

    // Each bit is written straight into its final position; unwritten
    // low bits stay zero, which gives the left-justified partial result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (strobe && in_range) begin
            acc[pos] <= sdata;
        end
    end
endmodule

// File: rtl/adc_result_align.sv
module adc_result_align #(
    parameter int RES   = 12,
    parameter int OUT_W = 16
) (
    input  logic [RES-1:0]          acc,
    input  logic signed [RES-1:0]   win_hi,
    input  logic signed [RES-1:0]   win_lo,
    output logic signed [OUT_W-1:0] sample_ext,
    output logic                    outside
);
    logic signed [RES-1:0] acc_s;

    assign acc_s      = signed'(acc);
    assign sample_ext = OUT_W'(acc_s);
    assign outside    = (acc_s > win_hi) || (acc_s < win_lo);
endmodule

// File: rtl/adc_shortcycle_host.sv
module adc_shortcycle_host #(
    parameter int RES   = 12,
    parameter int OUT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(RES+1)-1:0] nbits,
    input  logic [DIV_W-1:0]         div_half,
    input  logic signed [RES-1:0]    win_hi,
    input  logic signed [RES-1:0]    win_lo,
    input  logic                     sdata_i,
    output logic                     cs_n_o,
    output logic                     sclk_o,
    output logic                     busy_o,
    output logic                     valid_o,
    output logic signed [OUT_W-1:0]  sample_o,
    output logic                     out_of_range_o
);
    import adc_host_pkg::*;

    localparam int NB_W  = $clog2(RES + 1);
    localparam int CNT_W = $clog2(RES + SKIP_EDGES + 1);

    host_state_e             state_q, state_d;
    logic [NB_W-1:0]         nlat_q, n_clamped;
    logic [DIV_W-1:0]        dlat_q, tmr_half;
    logic [CNT_W-1:0]        rise_q;
    logic                    tmr_load, tmr_done;
    logic                    accept, rise_edge, last_rise, finish;
    logic [RES-1:0]          acc;
    logic signed [OUT_W-1:0] sample_ext;
    logic                    outside;

    always_comb begin
        if (nbits == '0)
            n_clamped = NB_W'(1);
        else if (nbits > NB_W'(RES))
            n_clamped = NB_W'(RES);
        else
            n_clamped = nbits;
    end

    assign accept    = (state_q == ST_IDLE) && start;
    assign tmr_half  = (state_q == ST_IDLE) ? div_half : dlat_q;
    assign tmr_load  = (state_q == ST_IDLE) || tmr_done;
    assign last_rise = (rise_q == (CNT_W'(nlat_q) + CNT_W'(SKIP_EDGES)));

    adc_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .half  (tmr_half),
        .done  (tmr_done)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_d = ST_LEAD;
            ST_LEAD:    if (tmr_done) state_d = ST_SCK_HI;
            ST_SCK_HI:  if (tmr_done) state_d = last_rise ? ST_RECOVER : ST_SCK_LO;
            ST_SCK_LO:  if (tmr_done) state_d = ST_SCK_HI;
            ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rise_edge = (state_d == ST_SCK_HI) && (state_q != ST_SCK_HI);
    assign finish    = (state_q == ST_SCK_HI) && (state_d == ST_RECOVER);

    adc_bit_capture #(.RES(RES), .CNT_W(CNT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .strobe   (rise_edge),
        .rise_idx (rise_q + CNT_W'(1)),
        .sdata    (sdata_i),
        .acc      (acc)
    );

    adc_result_align #(.RES(RES), .OUT_W(OUT_W)) u_align (
        .acc        (acc),
        .win_hi     (win_hi),
        .win_lo     (win_lo),
        .sample_ext (sample_ext),
        .outside    (outside)
    );

    // Registered outputs and per-conversion context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o         <= 1'b1;
            sclk_o         <= 1'b0;
            valid_o        <= 1'b0;
            sample_o       <= '0;
            out_of_range_o <= 1'b0;
            nlat_q         <= NB_W'(1);
            dlat_q         <= '0;
            rise_q         <= '0;
        end else begin
            cs_n_o  <= !((state_d == ST_LEAD) || (state_d == ST_SCK_HI) ||
                         (state_d == ST_SCK_LO));
            sclk_o  <= (state_d == ST_SCK_HI);
            valid_o <= finish;
            if (finish) begin
                sample_o       <= sample_ext;
                out_of_range_o <= outside;
            end
            if (accept) begin
                nlat_q <= n_clamped;
                dlat_q <= div_half;
                rise_q <= '0;
            end else if (rise_edge) begin
                rise_q <= rise_q + CNT_W'(1);
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_shortcycle_host_chk.sv
module adc_shortcycle_host_chk #(
    parameter int RES   = 12,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy_o,
    input logic             cs_n_o,
    input logic             sclk_o,
    input logic             valid_o,
    input logic [OUT_W-1:0] sample_o,
    input logic             out_of_range_o
);
    logic [7:0] rises_q;
    logic       sclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises_q   <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            if (cs_n_o)
                rises_q <= '0;
            else if (sclk_o && !sclk_prev)
                rises_q <= rises_q + 8'd1;
        end
    end

    a_r3_clock_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r5_release_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(cs_n_o));

    a_r8_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start) && !$past(busy_o)));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(sample_o) && $stable(out_of_range_o)));

    // R11: never more than RES + 3 rising edges in one select-low window
    a_r11_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rises_q) <= RES + 3);
endmodule

bind adc_shortcycle_host adc_shortcycle_host_chk #(.RES(RES), .OUT_W(OUT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy_o         (busy_o),
    .cs_n_o         (cs_n_o),
    .sclk_o         (sclk_o),
    .valid_o        (valid_o),
    .sample_o       (sample_o),
    .out_of_range_o (out_of_range_o)
);

// File: tb/adc_shortcycle_host_tb.sv
module adc_shortcycle_host_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n = 1'b0, start = 1'b0, sdata = 1'b0;
    logic [3:0]         nbits = 4'd12;
    logic [7:0]         div_half = 8'd0;
    logic signed [11:0] win_hi = 12'sh7FF, win_lo = 12'sh800;
    logic               cs_n, sclk, busy, valid, oor;
    logic signed [15:0] sample;

    adc_shortcycle_host u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits),
        .div_half(div_half), .win_hi(win_hi), .win_lo(win_lo),
        .sdata_i(sdata), .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy),
        .valid_o(valid), .sample_o(sample), .out_of_range_o(oor)
    );

    int n_cmp = 0, n_bad = 0;
    logic [11:0] code_m = '0;
    int falls = 0, rises = 0, run = 0, ph_bad = 0, exp_p = 1;
    logic prev_sclk = 1'b0;

    // Converter model plus phase-length monitor, evaluated off the active edge
    always @(negedge clk) begin
        if (cs_n) begin
            falls = 0; sdata = 1'b0; run = 0;
        end else begin
            if (prev_sclk && !sclk) begin
                falls++;
                if (falls >= 3 && falls <= 14)       sdata = code_m[14-falls];
                else if (falls >= 15 && falls <= 25) sdata = code_m[falls-14];
                else                                 sdata = 1'b0;
            end
            if (!prev_sclk && sclk) rises++;
            if (sclk != prev_sclk) begin
                if (run != exp_p) ph_bad++;
                run = 1;
            end else begin
                run++;
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic conv(input logic [11:0] code, input int nb, input int dv,
                        input logic signed [11:0] hi, input logic signed [11:0] lo,
                        input bit disturb, input bit tail_start);
        int ne, p, n;
        logic [11:0] m;
        logic signed [11:0] a;
        logic [15:0] e;
        bit eo;
        ne = (nb == 0) ? 1 : ((nb > 12) ? 12 : nb);
        p  = dv + 1;
        m  = 12'hFFF << (12 - ne);
        a  = signed'(code & m);
        e  = {{4{a[11]}}, a};
        eo = (a > hi) || (a < lo);
        @(negedge clk);
        code_m = code; nbits = nb[3:0]; div_half = dv[7:0];
        win_hi = hi; win_lo = lo; exp_p = p; rises = 0; ph_bad = 0; start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                chk("R2 select low after start", {31'd0, cs_n}, 32'd0);
                chk("R2 busy after start", {31'd0, busy}, 32'd1);
            end
            if (disturb && n == 3) begin
                start = 1'b1; nbits = 4'd2; div_half = 8'(dv + 3);  // R7 / R8
            end
            if (disturb && n == 4) start = 1'b0;
        end while (!valid && n < 3000);
        chk("R5 start-to-valid cycles", n, 2 * p * (ne + 3) + 1);
        chk("R5 select released with valid", {31'd0, cs_n}, 32'd1);
        chk("R4 rising edge count", rises, ne + 3);
        chk("R3 phase length", ph_bad, 0);
        chk("R6 aligned sample", {16'd0, sample}, {16'd0, e});
        chk("R9 window flag", {31'd0, oor}, {31'd0, eo});
        if (tail_start) start = 1'b1;
        repeat (p - 1) @(negedge clk);
        chk("R8 recovery still busy", {31'd0, busy}, 32'd1);
        start = 1'b0;
        @(negedge clk);
        chk("R8 idle after recovery", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R8 start during recovery ignored", {31'd0, cs_n}, 32'd1);
        chk("R10 sample held", {16'd0, sample}, {16'd0, e});
    endtask

    initial begin
        logic [11:0] codes [6];
        codes = '{12'h800, 12'h7FF, 12'h000, 12'hFFF, 12'hA5A, 12'h35C};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset select", {31'd0, cs_n}, 32'd1);
        chk("R1 reset clock", {31'd0, sclk}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset valid", {31'd0, valid}, 32'd0);
        chk("R1 reset sample", {16'd0, sample}, 32'd0);
        chk("R1 reset flag", {31'd0, oor}, 32'd0);
        for (int d = 0; d < 2; d++) begin
            for (int nb = 1; nb <= 12; nb++) begin   // nb=12 covers R11
                for (int ci = 0; ci < 6; ci++) begin
                    conv(codes[ci], nb, d * 2,
                         (ci % 2 == 1) ? 12'sh200 : 12'sh7FF,
                         (ci % 2 == 1) ? -12'sh180 : 12'sh800,
                         ci == 2, ci == 3);
                end
            end
        end
        // R7 clamping of out-of-range bit counts
        conv(12'hA5A, 0, 1, 12'sh100, -12'sh100, 1'b0, 1'b0);
        conv(12'h9C3, 15, 1, 12'sh100, -12'sh100, 1'b0, 1'b0);
        conv(12'h5E7, 13, 0, 12'sh100, -12'sh100, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule